// File: doc/BRIEF.md
# Debug Hart Handshake Controller

This block lets a debugger halt, run commands on and resume a set of processor harts without any dedicated halt or resume wires into their pipelines. A halt request raises a per-hart debug interrupt. The interrupted hart enters debug mode and spins in a park loop that runs from the controller's memory window. The hart and the controller talk only through that window. The hart writes its own index to a few status addresses to report that it is parked, that it has taken a command, that it is leaving, or that it faulted. It reads a per-hart flag byte to learn whether it should run the program buffer or resume.

On the debugger side, a command is a single-cycle issue aimed at one hart. The controller raises that hart's go flag and holds a busy bit. Busy drops when the hart has acknowledged the go flag and then reports itself parked again, or when it reports an exception. Misuse sets a sticky error code, and the offending command is dropped. A resume request raises a resume flag for a parked hart. The hart's resume acknowledge clears that flag together with its halted status.

Top module: `dbg_hart_ctrl`

## Requirements
- R1: After reset, every halted, go and resume flag is 0, cmd_busy is 0, cmd_err is 0 and bus_rdata is 0.
- R2: debug_irq[i] equals halt_req[i] while hart i is not halted. It is 0 from the cycle after hart i reports halted.
- R3: A bus write to 0x100 whose data is a hart index below NUM_HARTS sets that hart's halted bit on the next clock edge. Data of NUM_HARTS or more is ignored.
- R4: A bus read of 0x400+i, for i below NUM_HARTS, returns hart i's flags on bus_rdata one cycle later: bit 0 is go and bit 1 is resume. Any other read address, or a cycle with no read, gives 0.
- R5: A command (cmd_valid) is accepted when cmd_busy is 0, cmd_err is 0 and the target hart is halted. Acceptance sets cmd_busy and the target's go flag.
- R6: A bus write to 0x104 with a valid hart index clears that hart's go flag.
- R7: While busy, a write to 0x100 from the command's hart clears cmd_busy only if that hart's go flag is already clear. With go still set it has no effect on busy.
- R8: While busy, a write to 0x10C from the command's hart clears cmd_busy and the hart's go flag, and sets cmd_err to 3 if cmd_err was 0.
- R9: A command issued while cmd_busy is 1 sets cmd_err to 1 if cmd_err was 0. It changes no flag and does not change busy.
- R10: A command aimed at a hart that is not halted sets cmd_err to 2 if cmd_err was 0, and changes nothing else.
- R11: A nonzero cmd_err holds until err_clr. While it is nonzero every command is ignored. err_clr returns it to 0 on the next edge.
- R12: resume_req[i] sets hart i's resume flag only when hart i is halted and is not the hart of a busy command. Otherwise it is ignored.
- R13: A bus write to 0x108 with a valid hart index clears that hart's resume flag and halted bit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the debug logic |
| halt_req | input | NUM_HARTS | Per-hart halt request level from the debugger |
| resume_req | input | NUM_HARTS | Per-hart resume request pulse |
| cmd_valid | input | 1 | Command issue pulse |
| cmd_hart | input | IDX_W | Target hart of the command |
| err_clr | input | 1 | Clears the command error code |
| cmd_busy | output | 1 | A command is in flight |
| cmd_err | output | 2 | Error code: 0 none, 1 busy, 2 not halted, 3 exception |
| halted | output | NUM_HARTS | Per-hart parked status |
| debug_irq | output | NUM_HARTS | Per-hart debug interrupt |
| bus_wr | input | 1 | Hart-side write strobe |
| bus_rd | input | 1 | Hart-side read strobe |
| bus_addr | input | ADDR_W | Hart-side byte address |
| bus_wdata | input | DATA_W | Hart-side write data (hart index) |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The bench aims at the ordering hazards of the handshake. One is a parked hart rewriting its halted index while its go flag is still up; a design that took that as completion would drop busy before the command ran. Another is an exception arriving before the go acknowledge; a design that left go set would make the hart run the command a second time. The bench also issues commands in the same cycle as completion, while an error is pending, and to harts that are still running, where a design could overwrite the first error or start the command anyway. Out-of-range hart indices, resume requests for running or busy harts, and flag reads around every change complete the set, with long random traffic checked against a cycle model.

// File: rtl/dhc_pkg.sv
// Package: shared types for the debug hart handshake controller.
// Assumes a two-bit command error field and one hart-side access per cycle.
package dhc_pkg;

    typedef enum logic [1:0] {
        CMDERR_NONE       = 2'd0,
        CMDERR_BUSY       = 2'd1,
        CMDERR_NOT_HALTED = 2'd2,
        CMDERR_EXCEPTION  = 2'd3
    } cmderr_e;

    // One decoded hart-side status write; at most one field set per cycle.
    typedef struct packed {
        logic halted;
        logic going;
        logic resuming;
        logic except;
    } hart_evt_t;

endpackage

// File: rtl/dhc_addr_dec.sv
// Module: dhc_addr_dec
// Decodes hart-side bus accesses into status events and flag-read hits.
// Assumes the write data carries the writing hart's index; indices at or
// above NUM_HARTS produce no event.
module dhc_addr_dec
    import dhc_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2,
    parameter logic [ADDR_W-1:0] HALT_ADDR   = 12'h100,
    parameter logic [ADDR_W-1:0] GOING_ADDR  = 12'h104,
    parameter logic [ADDR_W-1:0] RESUME_ADDR = 12'h108,
    parameter logic [ADDR_W-1:0] EXCEPT_ADDR = 12'h10C,
    parameter logic [ADDR_W-1:0] FLAG_ADDR   = 12'h400
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output hart_evt_t         evt,
    output logic [IDX_W-1:0]  evt_idx,
    output logic              flag_hit,
    output logic [IDX_W-1:0]  flag_idx
);

    logic              idx_ok;
    logic [ADDR_W-1:0] flag_off;

    assign idx_ok   = bus_wdata < DATA_W'(NUM_HARTS);
    assign evt_idx  = bus_wdata[IDX_W-1:0];
    assign flag_off = bus_addr - FLAG_ADDR;

    // Status-write decode: one event for a known address and valid index.
    always_comb begin
        evt          = '0;
        evt.halted   = bus_wr && idx_ok && (bus_addr == HALT_ADDR);
        evt.going    = bus_wr && idx_ok && (bus_addr == GOING_ADDR);
        evt.resuming = bus_wr && idx_ok && (bus_addr == RESUME_ADDR);
        evt.except   = bus_wr && idx_ok && (bus_addr == EXCEPT_ADDR);
    end

    // Flag window decode: one byte per hart starting at FLAG_ADDR.
    always_comb begin
        flag_hit = bus_rd && (bus_addr >= FLAG_ADDR) && (flag_off < ADDR_W'(NUM_HARTS));
        flag_idx = flag_off[IDX_W-1:0];
    end

endmodule

// File: rtl/dhc_cmd_track.sv
// Module: dhc_cmd_track
// Tracks the single in-flight command: acceptance, busy, target hart and
// the sticky error code. Assumes halted_vec and go_vec are the registered
// per-hart flags and that status events carry a valid hart index.
module dhc_cmd_track
    import dhc_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [IDX_W-1:0]     cmd_hart,
    input  logic                 err_clr,
    input  logic [NUM_HARTS-1:0] halted_vec,
    input  logic [NUM_HARTS-1:0] go_vec,
    input  logic                 halt_evt,
    input  logic                 exc_evt,
    input  logic [IDX_W-1:0]     evt_idx,
    output logic                 busy,
    output cmderr_e              err,
    output logic [IDX_W-1:0]     cur_hart,
    output logic [NUM_HARTS-1:0] go_set,
    output logic [NUM_HARTS-1:0] go_kill,
    output logic                 exc_hit
);

    logic    busy_q;
    cmderr_e err_q;
    logic [IDX_W-1:0] cur_q;
    logic    tgt_halted;
    logic    accept;
    logic    same_hart;
    logic    done_hit;

    assign tgt_halted = (int'(cmd_hart) < NUM_HARTS) && halted_vec[cmd_hart];
    assign accept     = cmd_valid && !busy_q && (err_q == CMDERR_NONE) && tgt_halted;
    assign same_hart  = (evt_idx == cur_q);
    assign exc_hit    = busy_q && exc_evt && same_hart;
    assign done_hit   = busy_q && halt_evt && same_hart && !go_vec[cur_q];

    // One-hot go set for the accepted target and go kill on an exception.
    always_comb begin
        go_set  = '0;
        go_kill = '0;
        for (int i = 0; i < NUM_HARTS; i++) begin
            go_set[i]  = accept && (cmd_hart == IDX_W'(i));
            go_kill[i] = exc_hit && (cur_q == IDX_W'(i));
        end
    end

    // Busy and target hart: set on acceptance, cleared on completion or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cur_q  <= cmd_hart;
        end else if (done_hit || exc_hit) begin
            busy_q <= 1'b0;
        end
    end

    // Sticky error code: clear wins, then the first error to arrive is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= CMDERR_NONE;
        end else if (err_clr) begin
            err_q <= CMDERR_NONE;
        end else if (err_q == CMDERR_NONE) begin
            if (exc_hit)
                err_q <= CMDERR_EXCEPTION;
            else if (cmd_valid && busy_q)
                err_q <= CMDERR_BUSY;
            else if (cmd_valid && !tgt_halted)
                err_q <= CMDERR_NOT_HALTED;
        end
    end

    assign busy     = busy_q;
    assign err      = err_q;
    assign cur_hart = cur_q;

endmodule

// File: rtl/dhc_hart_flags.sv
// Module: dhc_hart_flags
// Holds each hart's halted, go and resume bits and forms its debug
// interrupt. Assumes at most one status event per cycle.
module dhc_hart_flags #(
    parameter int NUM_HARTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 halt_evt,
    input  logic                 going_evt,
    input  logic                 resume_evt,
    input  logic [IDX_W-1:0]     evt_idx,
    input  logic [NUM_HARTS-1:0] go_set,
    input  logic [NUM_HARTS-1:0] go_kill,
    input  logic [NUM_HARTS-1:0] resume_req,
    input  logic [NUM_HARTS-1:0] halt_req,
    input  logic                 busy,
    input  logic [IDX_W-1:0]     cur_hart,
    output logic [NUM_HARTS-1:0] halted_vec,
    output logic [NUM_HARTS-1:0] go_vec,
    output logic [NUM_HARTS-1:0] res_vec,
    output logic [NUM_HARTS-1:0] debug_irq
);

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
        logic sel;
        logic res_set;
        logic halted_q;
        logic go_q;
        logic res_q;

        assign sel     = (evt_idx == IDX_W'(i));
        assign res_set = resume_req[i] && halted_q && !(busy && (cur_hart == IDX_W'(i)));

        // Per-hart status: halted on report, released on resume acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                halted_q <= 1'b0;
            else if (halt_evt && sel)
                halted_q <= 1'b1;
            else if (resume_evt && sel)
                halted_q <= 1'b0;
        end

        // Per-hart go flag: raised by the command, dropped by ack or fault.
        always_ff @(posedge clk) begin
            if (!rst_n)
                go_q <= 1'b0;
            else if (go_set[i])
                go_q <= 1'b1;
            else if ((going_evt && sel) || go_kill[i])
                go_q <= 1'b0;
        end

        // Per-hart resume flag: acknowledge has priority over a new request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                res_q <= 1'b0;
            else if (resume_evt && sel)
                res_q <= 1'b0;
            else if (res_set)
                res_q <= 1'b1;
        end

        assign halted_vec[i] = halted_q;
        assign go_vec[i]     = go_q;
        assign res_vec[i]    = res_q;
        assign debug_irq[i]  = halt_req[i] && !halted_q;
    end

endmodule

// File: rtl/dbg_hart_ctrl.sv
// Module: dbg_hart_ctrl (top)
// Coordinates halt, command execution and resume for NUM_HARTS harts that
// park in the controller's memory window. Assumes one hart-side access per
// cycle and a debugger that issues single-cycle command and resume pulses.
module dbg_hart_ctrl
    import dhc_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter logic [ADDR_W-1:0] HALT_ADDR   = 12'h100,
    parameter logic [ADDR_W-1:0] GOING_ADDR  = 12'h104,
    parameter logic [ADDR_W-1:0] RESUME_ADDR = 12'h108,
    parameter logic [ADDR_W-1:0] EXCEPT_ADDR = 12'h10C,
    parameter logic [ADDR_W-1:0] FLAG_ADDR   = 12'h400,
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HARTS-1:0] halt_req,
    input  logic [NUM_HARTS-1:0] resume_req,
    input  logic                 cmd_valid,
    input  logic [IDX_W-1:0]     cmd_hart,
    input  logic                 err_clr,
    output logic                 cmd_busy,
    output logic [1:0]           cmd_err,
    output logic [NUM_HARTS-1:0] halted,
    output logic [NUM_HARTS-1:0] debug_irq,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata
);

    hart_evt_t            evt;
    logic [IDX_W-1:0]     evt_idx;
    logic                 flag_hit;
    logic [IDX_W-1:0]     flag_idx;
    logic [NUM_HARTS-1:0] halted_q;
    logic [NUM_HARTS-1:0] go_q;
    logic [NUM_HARTS-1:0] res_q;
    logic [NUM_HARTS-1:0] go_set;
    logic [NUM_HARTS-1:0] go_kill;
    logic                 busy;
    cmderr_e              err;
    logic [IDX_W-1:0]     cur_hart;
    logic                 exc_hit;
    logic [DATA_W-1:0]    rdata_q;

    dhc_addr_dec #(
        .NUM_HARTS  (NUM_HARTS),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .HALT_ADDR  (HALT_ADDR),
        .GOING_ADDR (GOING_ADDR),
        .RESUME_ADDR(RESUME_ADDR),
        .EXCEPT_ADDR(EXCEPT_ADDR),
        .FLAG_ADDR  (FLAG_ADDR)
    ) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .evt      (evt),
        .evt_idx  (evt_idx),
        .flag_hit (flag_hit),
        .flag_idx (flag_idx)
    );

    dhc_cmd_track #(
        .NUM_HARTS(NUM_HARTS),
        .IDX_W    (IDX_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_hart  (cmd_hart),
        .err_clr   (err_clr),
        .halted_vec(halted_q),
        .go_vec    (go_q),
        .halt_evt  (evt.halted),
        .exc_evt   (evt.except),
        .evt_idx   (evt_idx),
        .busy      (busy),
        .err       (err),
        .cur_hart  (cur_hart),
        .go_set    (go_set),
        .go_kill   (go_kill),
        .exc_hit   (exc_hit)
    );

    dhc_hart_flags #(
        .NUM_HARTS(NUM_HARTS),
        .IDX_W    (IDX_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_evt  (evt.halted),
        .going_evt (evt.going),
        .resume_evt(evt.resuming),
        .evt_idx   (evt_idx),
        .go_set    (go_set),
        .go_kill   (go_kill),
        .resume_req(resume_req),
        .halt_req  (halt_req),
        .busy      (busy),
        .cur_hart  (cur_hart),
        .halted_vec(halted_q),
        .go_vec    (go_q),
        .res_vec   (res_q),
        .debug_irq (debug_irq)
    );

    // Registered flag read: {resume, go} of the addressed hart, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (flag_hit)
            rdata_q <= DATA_W'({res_q[flag_idx], go_q[flag_idx]});
        else
            rdata_q <= '0;
    end

    assign cmd_busy  = busy;
    assign cmd_err   = err;
    assign halted    = halted_q;
    assign bus_rdata = rdata_q;

endmodule

// File: rtl/dbg_hart_ctrl_chk.sv
// Module: dbg_hart_ctrl_chk
// Temporal checks on the handshake controller, bound to every instance.
module dbg_hart_ctrl_chk #(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2,
    parameter logic [ADDR_W-1:0] RESUME_ADDR = 12'h108
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 err_clr,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 cmd_busy,
    input logic [1:0]           cmd_err,
    input logic [NUM_HARTS-1:0] halted,
    input logic [NUM_HARTS-1:0] go_vec,
    input logic [NUM_HARTS-1:0] res_vec,
    input logic                 exc_hit
);

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> $past(cmd_valid));

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy) |-> $past(bus_wr));

    // R6
    go_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|go_vec) |-> cmd_busy);

    // R9
    busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_busy && cmd_err == 2'd0 && !exc_hit && !err_clr) |=> cmd_err == 2'd1);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err != 2'd0 && !err_clr) |=> $stable(cmd_err));

    // R13
    resume_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RESUME_ADDR && bus_wdata < DATA_W'(NUM_HARTS))
        |=> (!halted[$past(bus_wdata[IDX_W-1:0])] && !res_vec[$past(bus_wdata[IDX_W-1:0])]));

endmodule

bind dbg_hart_ctrl dbg_hart_ctrl_chk #(
    .NUM_HARTS  (NUM_HARTS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .RESUME_ADDR(RESUME_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .err_clr  (err_clr),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cmd_busy (cmd_busy),
    .cmd_err  (cmd_err),
    .halted   (halted),
    .go_vec   (go_q),
    .res_vec  (res_q),
    .exc_hit  (exc_hit)
);

// File: tb/tb_dbg_hart_ctrl.sv
// Bench for dbg_hart_ctrl: directed handshake flows, then seeded random
// traffic, all compared against a cycle model built from the requirements.
module tb_dbg_hart_ctrl;

    localparam int N = 4;
    localparam int IW = 2;
    localparam logic [11:0] A_HALT = 12'h100;
    localparam logic [11:0] A_GOING = 12'h104;
    localparam logic [11:0] A_RES = 12'h108;
    localparam logic [11:0] A_EXC = 12'h10C;
    localparam logic [11:0] A_FLAG = 12'h400;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  halt_req;
    logic [N-1:0]  resume_req;
    logic          cmd_valid;
    logic [IW-1:0] cmd_hart;
    logic          err_clr;
    logic          cmd_busy;
    logic [1:0]    cmd_err;
    logic [N-1:0]  halted;
    logic [N-1:0]  debug_irq;
    logic          bus_wr;
    logic          bus_rd;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;

    int compared = 0;
    int mismatched = 0;

    // Model state
    logic [N-1:0] m_halted, m_go, m_res;
    logic         m_busy;
    logic [1:0]   m_err;
    int           m_cur;
    logic [31:0]  m_rdata;

    dbg_hart_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .resume_req(resume_req),
        .cmd_valid(cmd_valid), .cmd_hart(cmd_hart), .err_clr(err_clr),
        .cmd_busy(cmd_busy), .cmd_err(cmd_err), .halted(halted),
        .debug_irq(debug_irq), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        mismatched++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        resume_req = '0; cmd_valid = 1'b0; cmd_hart = '0; err_clr = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    function automatic logic [31:0] flag_val(input logic [11:0] a, input logic rd);
        int off;
        off = int'(a) - int'(A_FLAG);
        if (rd && a >= A_FLAG && off < N) return {30'd0, m_res[off], m_go[off]};
        return 32'd0;
    endfunction

    // Next-state model computed from the requirements and current inputs.
    task automatic model_step();
        logic [N-1:0] n_halted, n_go, n_res;
        logic n_busy; logic [1:0] n_err; int n_cur;
        logic ok, hw, gw, rw, ew, exc, done, tgt, acc;
        int idx;
        ok = bus_wdata < N; idx = int'(bus_wdata[IW-1:0]);
        hw = bus_wr && ok && bus_addr == A_HALT;
        gw = bus_wr && ok && bus_addr == A_GOING;
        rw = bus_wr && ok && bus_addr == A_RES;
        ew = bus_wr && ok && bus_addr == A_EXC;
        exc = m_busy && ew && idx == m_cur;
        done = m_busy && hw && idx == m_cur && !m_go[m_cur];
        tgt = m_halted[cmd_hart];
        acc = cmd_valid && !m_busy && m_err == 2'd0 && tgt;
        n_halted = m_halted; n_go = m_go; n_res = m_res;
        for (int i = 0; i < N; i++) begin
            if (hw && idx == i) n_halted[i] = 1'b1;
            if (rw && idx == i) n_halted[i] = 1'b0;
            if ((gw && idx == i) || (exc && m_cur == i)) n_go[i] = 1'b0;
            if (acc && int'(cmd_hart) == i) n_go[i] = 1'b1;
            if (resume_req[i] && m_halted[i] && !(m_busy && m_cur == i)) n_res[i] = 1'b1;
            if (rw && idx == i) n_res[i] = 1'b0;
        end
        n_busy = acc ? 1'b1 : ((done || exc) ? 1'b0 : m_busy);
        n_cur = acc ? int'(cmd_hart) : m_cur;
        n_err = m_err;
        if (err_clr) n_err = 2'd0;
        else if (m_err == 2'd0) begin
            if (exc) n_err = 2'd3;
            else if (cmd_valid && m_busy) n_err = 2'd1;
            else if (cmd_valid && !tgt) n_err = 2'd2;
        end
        m_rdata = flag_val(bus_addr, bus_rd);
        m_halted = n_halted; m_go = n_go; m_res = n_res;
        m_busy = n_busy; m_err = n_err; m_cur = n_cur;
    endtask

    // One clock with inputs as set; compare all outputs mid-low phase.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R3 halted", 32'(halted), 32'(m_halted));
        chk("R7 busy", 32'(cmd_busy), 32'(m_busy));
        chk("R11 err", 32'(cmd_err), 32'(m_err));
        chk("R2 irq", 32'(debug_irq), 32'(halt_req & ~m_halted));
        chk("R4 rdata", bus_rdata, m_rdata);
        idle_inputs();
    endtask

    task automatic hwrite(input logic [11:0] a, input int idx);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = 32'(idx); cycle();
    endtask

    task automatic fread(input int h);
        bus_rd = 1'b1; bus_addr = A_FLAG + 12'(h); cycle();
    endtask

    task automatic issue(input int h);
        cmd_valid = 1'b1; cmd_hart = IW'(h); cycle();
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        idle_inputs();
        halt_req = '0;
        rst_n = 1'b0;
        m_halted = '0; m_go = '0; m_res = '0; m_busy = 1'b0; m_err = 2'd0; m_cur = 0; m_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 halted", 32'(halted), 0);
        chk("R1 busy", 32'(cmd_busy), 0);
        chk("R1 err", 32'(cmd_err), 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 irq", 32'(debug_irq), 0);

        halt_req = 4'b0100; cycle();
        chk("R2 irq raised", 32'(debug_irq), 32'h4);
        hwrite(A_HALT, 2);
        chk("R3 halted set", 32'(halted), 32'h4);
        chk("R2 irq dropped", 32'(debug_irq), 0);
        hwrite(A_HALT, 7);
        chk("R3 out-of-range ignored", 32'(halted), 32'h4);

        issue(1);
        chk("R10 not halted err", 32'(cmd_err), 2);
        chk("R10 no busy", 32'(cmd_busy), 0);
        issue(2);
        chk("R11 ignored while err", 32'(cmd_busy), 0);
        err_clr = 1'b1; cycle();
        chk("R11 cleared", 32'(cmd_err), 0);

        issue(2);
        chk("R5 busy set", 32'(cmd_busy), 1);
        fread(2);
        chk("R5 go flag", bus_rdata, 32'h1);
        issue(2);
        chk("R9 busy err", 32'(cmd_err), 1);
        chk("R9 still busy", 32'(cmd_busy), 1);
        err_clr = 1'b1; cycle();
        hwrite(A_HALT, 2);
        chk("R7 no early completion", 32'(cmd_busy), 1);
        hwrite(A_GOING, 2);
        fread(2);
        chk("R6 go cleared", bus_rdata, 32'h0);
        hwrite(A_HALT, 2);
        chk("R7 completed", 32'(cmd_busy), 0);

        issue(2);
        hwrite(A_EXC, 2);
        chk("R8 busy cleared", 32'(cmd_busy), 0);
        chk("R8 err exception", 32'(cmd_err), 3);
        fread(2);
        chk("R8 go cleared", bus_rdata, 32'h0);
        err_clr = 1'b1; cycle();

        resume_req = 4'b0010; cycle();
        fread(1);
        chk("R12 not halted ignored", bus_rdata, 32'h0);
        issue(2);
        resume_req = 4'b0100; cycle();
        fread(2);
        chk("R12 busy hart ignored", bus_rdata, 32'h1);
        hwrite(A_GOING, 2);
        hwrite(A_HALT, 2);
        resume_req = 4'b0100; cycle();
        fread(2);
        chk("R12 resume flag", bus_rdata, 32'h2);
        hwrite(A_RES, 2);
        chk("R13 halted cleared", 32'(halted), 32'h0);
        fread(2);
        chk("R13 resume cleared", bus_rdata, 32'h0);

        // Seeded random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            int r;
            if ($urandom % 8 == 0) halt_req = N'($urandom);
            cmd_valid = ($urandom % 5 == 0);
            cmd_hart = IW'($urandom);
            err_clr = ($urandom % 9 == 0);
            if ($urandom % 4 == 0) resume_req = N'($urandom);
            r = int'($urandom % 12);
            bus_wdata = 32'($urandom % (N + 2));
            case (r)
                0, 1: begin bus_wr = 1'b1; bus_addr = A_HALT; end
                2, 3: begin bus_wr = 1'b1; bus_addr = A_GOING; end
                4:    begin bus_wr = 1'b1; bus_addr = A_RES; end
                5:    begin bus_wr = 1'b1; bus_addr = A_EXC; end
                6, 7, 8: begin bus_rd = 1'b1; bus_addr = A_FLAG + 12'($urandom % (N + 2)); end
                9:    begin bus_rd = 1'b1; bus_addr = A_HALT; end
                default: ;
            endcase
            cycle();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule